// File: doc/BRIEF.md
# Prescaled Auto-Reload Timer

This block is a general-purpose up-counting timer that sits on a simple register bus. A 16-bit prescaler divides the input clock, and the counter steps once per prescaled tick. The counter runs up to a programmable reload limit, returns to zero on the next tick and raises an update event. If the matching enable bits are set, the update event sets a status flag and sends a one-cycle interrupt pulse.

Software starts and stops the count with an enable bit. It can load the counter directly, force a restart through an event-generation bit, and change the tick rate while the count is in progress. Four compare holding registers are included as plain storage for software. Status flags are cleared by writing 0 to them, because the written word is ANDed into the status register.

Reads are registered. The read data for an address appears in the cycle after that address is presented. Writes take effect on the clock edge where the write enable is sampled high. All addresses are byte offsets, and the two lowest address bits are expected to be 0.

Top module: `arl_timer`

## Requirements
- R1: A synchronous reset clears every register: enable, interrupt enable, status, prescaler, counter, reload limit and the compare registers. Every readable offset then returns 0, and the interrupt output is low.
- R2: While the enable bit (offset 0x00, bit 0) is 1, the counter advances once every PSC+1 clock cycles, where PSC is the prescaler value. While the enable bit is 0, neither the counter nor the prescaler phase moves.
- R3: A write to the prescaler (offset 0x28) keeps only the low 16 bits of the written word.
- R4: A prescaler write leaves the counter value unchanged and restarts the prescaler phase. From then on, ticks come at the new rate.
- R5: A write to the counter (offset 0x24) loads the low 16 bits of the word into the counter and restarts the prescaler phase. Reading offset 0x24 returns the current count.
- R6: Writing the event-generation register (offset 0x14) with bit 0 set forces the counter to 0 and restarts the prescaler phase. A write with bit 0 clear has no effect. The register always reads 0.
- R7: When a tick arrives while the counter equals a nonzero reload limit (offset 0x2C), the counter becomes 0 on that tick and an update event occurs.
- R8: An update event sets status bit 0 (offset 0x10) and drives `irq` high for exactly one cycle, in the cycle after the event. This happens only when the update-interrupt enable (offset 0x0C, bit 0) is set. With that enable clear, the counter still wraps but the flag and `irq` stay low.
- R9: A write to the status register replaces it with the AND of its old value and the written word. Writing 1 leaves a flag unchanged, and writing 0 clears it. A flag set in the same cycle wins over the clear.
- R10: While the reload limit is 0, no update event occurs. The counter runs freely through its whole 16-bit range.
- R11: The four compare registers (offsets 0x34, 0x38, 0x3C, 0x40) store the low 16 bits of what is written and return that value when read. They have no other effect.
- R12: A read of an unmapped offset returns 0. A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register being accessed |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data for the address presented in the previous cycle |
| irq | output | 1 | One-cycle update interrupt pulse |

## Verification
The checker watches these properties on every cycle:
- the interrupt is a single-cycle pulse and the status flag is already set when it appears;
- the counter wraps to zero after a tick at the reload limit;
- a stopped counter with no bus write holds its value;
- a zero reload limit never produces an interrupt;
- unmapped reads return zero.

Some behaviour needs whole scenarios and can only be shown by the bench:
- the tick rate for a given prescaler value;
- the count that survives a prescaler change;
- field truncation;
- the AND rule for status writes;
- the restart by the event-generation bit;
- the number of interrupts over a counting window.

// File: rtl/arl_timer_pkg.sv
`timescale 1ns/1ps
package arl_timer_pkg;
  // Byte offsets of the mapped registers
  localparam logic [7:0] OFF_CTRL  = 8'h00;
  localparam logic [7:0] OFF_IEN   = 8'h0C;
  localparam logic [7:0] OFF_STAT  = 8'h10;
  localparam logic [7:0] OFF_EVGEN = 8'h14;
  localparam logic [7:0] OFF_COUNT = 8'h24;
  localparam logic [7:0] OFF_DIV   = 8'h28;
  localparam logic [7:0] OFF_LIMIT = 8'h2C;
  localparam logic [7:0] OFF_CMP0  = 8'h34;
  localparam int unsigned CMP_STRIDE = 4;

  // Decoded bus strobes handed from the register file to the datapath
  typedef struct packed {
    logic load_cnt;
    logic restart;
    logic div_wr;
  } strobe_t;
endpackage

// File: rtl/arl_prescaler.sv
`timescale 1ns/1ps
module arl_prescaler #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  logic [PSC_W-1:0] phase_q;

  assign tick = en && (phase_q == div);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (en) begin
      if (tick) phase_q <= '0;
      else      phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/arl_counter.sv
`timescale 1ns/1ps
module arl_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             upd
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_limit;

  assign at_limit = (limit != '0) && (cnt_q == limit);
  // a bus write to the count in the same cycle overrides the wrap and its event
  assign upd      = tick && at_limit && !clear && !load;
  assign cnt      = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clear) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick) begin
      if (at_limit) cnt_q <= '0;
      else          cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/arl_regs.sv
`timescale 1ns/1ps
module arl_regs
  import arl_timer_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PSC_W   = 16,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_CMP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              upd,
  output logic              cen,
  output logic              uie,
  output logic              uif,
  output logic [PSC_W-1:0]  div,
  output logic [CNT_W-1:0]  limit,
  output strobe_t           strb
);
  localparam int unsigned CPAD = DATA_W - CNT_W;
  localparam int unsigned PPAD = DATA_W - PSC_W;

  logic             cen_q, uie_q, uif_q;
  logic [PSC_W-1:0] div_q;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] cmp_q [NUM_CMP];
  logic [NUM_CMP-1:0] cmp_hit;
  logic [DATA_W-1:0]  rd_next;
  logic [DATA_W-1:0]  rd_q;

  logic hit_ctrl, hit_ien, hit_stat, hit_evgen, hit_count, hit_div, hit_limit;

  assign hit_ctrl  = (bus_addr == ADDR_W'(OFF_CTRL));
  assign hit_ien   = (bus_addr == ADDR_W'(OFF_IEN));
  assign hit_stat  = (bus_addr == ADDR_W'(OFF_STAT));
  assign hit_evgen = (bus_addr == ADDR_W'(OFF_EVGEN));
  assign hit_count = (bus_addr == ADDR_W'(OFF_COUNT));
  assign hit_div   = (bus_addr == ADDR_W'(OFF_DIV));
  assign hit_limit = (bus_addr == ADDR_W'(OFF_LIMIT));

  assign strb.load_cnt = bus_we && hit_count;
  assign strb.restart  = bus_we && hit_evgen && bus_wdata[0];
  assign strb.div_wr   = bus_we && hit_div;

  always_ff @(posedge clk) begin
    if (rst) begin
      cen_q   <= 1'b0;
      uie_q   <= 1'b0;
      uif_q   <= 1'b0;
      div_q   <= '0;
      limit_q <= '0;
    end else begin
      if (bus_we && hit_ctrl)  cen_q   <= bus_wdata[0];
      if (bus_we && hit_ien)   uie_q   <= bus_wdata[0];
      if (bus_we && hit_div)   div_q   <= bus_wdata[PSC_W-1:0];
      if (bus_we && hit_limit) limit_q <= bus_wdata[CNT_W-1:0];
      // hardware set wins over a software clear in the same cycle
      uif_q <= (uif_q & ~(bus_we && hit_stat && !bus_wdata[0])) | (upd && uie_q);
    end
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    assign cmp_hit[g] = (bus_addr == ADDR_W'(OFF_CMP0 + 8'(g * CMP_STRIDE)));
    always_ff @(posedge clk) begin
      if (rst)                       cmp_q[g] <= '0;
      else if (bus_we && cmp_hit[g]) cmp_q[g] <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    if (hit_ctrl)  rd_next = DATA_W'(cen_q);
    if (hit_ien)   rd_next = DATA_W'(uie_q);
    if (hit_stat)  rd_next = DATA_W'(uif_q);
    if (hit_count) rd_next = {{CPAD{1'b0}}, cnt};
    if (hit_div)   rd_next = {{PPAD{1'b0}}, div_q};
    if (hit_limit) rd_next = {{CPAD{1'b0}}, limit_q};
    for (int i = 0; i < NUM_CMP; i++) begin
      if (cmp_hit[i]) rd_next = {{CPAD{1'b0}}, cmp_q[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_next;
  end

  assign bus_rdata = rd_q;
  assign cen       = cen_q;
  assign uie       = uie_q;
  assign uif       = uif_q;
  assign div       = div_q;
  assign limit     = limit_q;
endmodule

// File: rtl/arl_timer.sv
`timescale 1ns/1ps
module arl_timer
  import arl_timer_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned PSC_W   = 16,
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_CMP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic             cen, uie, uif, tick, upd, irq_q;
  logic [PSC_W-1:0] div;
  logic [CNT_W-1:0] limit, cnt;
  strobe_t          strb;

  arl_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PSC_W(PSC_W),
    .CNT_W(CNT_W), .NUM_CMP(NUM_CMP)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt(cnt), .upd(upd),
    .cen(cen), .uie(uie), .uif(uif), .div(div), .limit(limit), .strb(strb)
  );

  arl_prescaler #(.PSC_W(PSC_W)) u_div (
    .clk(clk), .rst(rst), .en(cen),
    .restart(strb.div_wr | strb.load_cnt | strb.restart),
    .div(div), .tick(tick)
  );

  arl_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load(strb.load_cnt),
    .load_val(bus_wdata[CNT_W-1:0]), .clear(strb.restart),
    .limit(limit), .cnt(cnt), .upd(upd)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= upd && uie && cen;
  end

  assign irq = irq_q;
endmodule

// File: rtl/arl_timer_chk.sv
`timescale 1ns/1ps
module arl_timer_chk
  import arl_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              cen,
  input logic              uif,
  input logic              tick,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  limit
);
  logic unmapped;
  assign unmapped = !(bus_addr inside {ADDR_W'(OFF_CTRL), ADDR_W'(OFF_IEN),
    ADDR_W'(OFF_STAT), ADDR_W'(OFF_EVGEN), ADDR_W'(OFF_COUNT), ADDR_W'(OFF_DIV),
    ADDR_W'(OFF_LIMIT), ADDR_W'(8'h34), ADDR_W'(8'h38), ADDR_W'(8'h3C), ADDR_W'(8'h40)});

  // R8
  irq_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  // R8
  irq_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> uif);
  // R7
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && limit != '0 && cnt == limit && !bus_we) |=> (cnt == '0));
  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!cen && !bus_we) |=> $stable(cnt));
  // R10
  zero_limit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (limit == '0 && !bus_we) |=> !irq);
  // R12
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    unmapped |=> (bus_rdata == '0));
endmodule

bind arl_timer arl_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we), .bus_rdata(bus_rdata),
  .irq(irq), .cen(cen), .uif(uif), .tick(tick), .cnt(cnt), .limit(limit)
);

// File: tb/arl_timer_bench.sv
`timescale 1ns/1ps
module arl_timer_bench;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam int K_WR = 0, K_RD = 1, K_IDLE = 2, K_IRQ = 3;

  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] expv;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 64;
  localparam vec_t VEC [NV] = '{
    '{K_RD,   8'h00, 32'h0,        32'h0,    8'd1},  // R1 control reset
    '{K_RD,   8'h2C, 32'h0,        32'h0,    8'd1},  // R1 limit reset
    '{K_WR,   8'h3C, 32'h0001_1234, 32'h0,   8'd11}, // R11
    '{K_RD,   8'h3C, 32'h0,        32'h1234, 8'd11},
    '{K_WR,   8'h34, 32'h0000_ABCD, 32'h0,   8'd11},
    '{K_RD,   8'h34, 32'h0,        32'hABCD, 8'd11},
    '{K_WR,   8'h28, 32'h0003_0002, 32'h0,   8'd3},  // R3 upper half dropped
    '{K_RD,   8'h28, 32'h0,        32'h2,    8'd3},
    '{K_WR,   8'h2C, 32'd100,      32'h0,    8'd2},  // R2 divide by 3, 12 cycles
    '{K_WR,   8'h00, 32'h1,        32'h0,    8'd2},
    '{K_IDLE, 8'h00, 32'd11,       32'h0,    8'd2},
    '{K_WR,   8'h00, 32'h0,        32'h0,    8'd2},
    '{K_RD,   8'h24, 32'h0,        32'd4,    8'd2},
    '{K_WR,   8'h28, 32'h0,        32'h0,    8'd4},  // R4 rate change keeps 4
    '{K_RD,   8'h24, 32'h0,        32'd4,    8'd4},
    '{K_WR,   8'h00, 32'h1,        32'h0,    8'd4},
    '{K_IDLE, 8'h00, 32'd4,        32'h0,    8'd4},
    '{K_WR,   8'h00, 32'h0,        32'h0,    8'd4},
    '{K_RD,   8'h24, 32'h0,        32'd9,    8'd4},
    '{K_IDLE, 8'h00, 32'd5,        32'h0,    8'd2},  // R2 stopped counter holds
    '{K_RD,   8'h24, 32'h0,        32'd9,    8'd2},
    '{K_WR,   8'h24, 32'h0000_0050, 32'h0,   8'd5},  // R5
    '{K_RD,   8'h24, 32'h0,        32'h50,   8'd5},
    '{K_WR,   8'h24, 32'h0001_2345, 32'h0,   8'd5},
    '{K_RD,   8'h24, 32'h0,        32'h2345, 8'd5},
    '{K_WR,   8'h24, 32'd7,        32'h0,    8'd6},  // R6
    '{K_WR,   8'h14, 32'h0,        32'h0,    8'd6},
    '{K_RD,   8'h24, 32'h0,        32'd7,    8'd6},
    '{K_WR,   8'h14, 32'h1,        32'h0,    8'd6},
    '{K_RD,   8'h24, 32'h0,        32'd0,    8'd6},
    '{K_RD,   8'h14, 32'h0,        32'd0,    8'd6},
    '{K_WR,   8'h2C, 32'd3,        32'h0,    8'd7},  // R7 limit 3, 10 ticks
    '{K_WR,   8'h0C, 32'h1,        32'h0,    8'd8},
    '{K_WR,   8'h00, 32'h1,        32'h0,    8'd7},
    '{K_IDLE, 8'h00, 32'd9,        32'h0,    8'd7},
    '{K_WR,   8'h00, 32'h0,        32'h0,    8'd7},
    '{K_RD,   8'h24, 32'h0,        32'd2,    8'd7},
    '{K_IRQ,  8'h00, 32'h0,        32'd2,    8'd8},  // R8 two pulses
    '{K_RD,   8'h10, 32'h0,        32'd1,    8'd8},
    '{K_WR,   8'h10, 32'hFFFF_FFFF, 32'h0,   8'd9},  // R9
    '{K_RD,   8'h10, 32'h0,        32'd1,    8'd9},
    '{K_WR,   8'h10, 32'hFFFF_FFFE, 32'h0,   8'd9},
    '{K_RD,   8'h10, 32'h0,        32'd0,    8'd9},
    '{K_WR,   8'h0C, 32'h0,        32'h0,    8'd8},  // R8 enable clear
    '{K_WR,   8'h24, 32'h0,        32'h0,    8'd8},
    '{K_WR,   8'h00, 32'h1,        32'h0,    8'd8},
    '{K_IDLE, 8'h00, 32'd9,        32'h0,    8'd8},
    '{K_WR,   8'h00, 32'h0,        32'h0,    8'd8},
    '{K_RD,   8'h24, 32'h0,        32'd2,    8'd8},
    '{K_IRQ,  8'h00, 32'h0,        32'd2,    8'd8},
    '{K_RD,   8'h10, 32'h0,        32'd0,    8'd8},
    '{K_WR,   8'h2C, 32'h0,        32'h0,    8'd10}, // R10
    '{K_WR,   8'h0C, 32'h1,        32'h0,    8'd10},
    '{K_WR,   8'h24, 32'h0,        32'h0,    8'd10},
    '{K_WR,   8'h00, 32'h1,        32'h0,    8'd10},
    '{K_IDLE, 8'h00, 32'd9,        32'h0,    8'd10},
    '{K_WR,   8'h00, 32'h0,        32'h0,    8'd10},
    '{K_RD,   8'h24, 32'h0,        32'd10,   8'd10},
    '{K_IRQ,  8'h00, 32'h0,        32'd2,    8'd10},
    '{K_RD,   8'h10, 32'h0,        32'd0,    8'd10},
    '{K_WR,   8'h04, 32'hFFFF_FFFF, 32'h0,   8'd12}, // R12
    '{K_RD,   8'h04, 32'h0,        32'd0,    8'd12},
    '{K_RD,   8'h30, 32'h0,        32'd0,    8'd12},
    '{K_RD,   8'h24, 32'h0,        32'd10,   8'd12}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_we = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic              irq;

  int tests = 0;
  int fails = 0;
  int irq_seen = 0;

  always #5 clk = ~clk;

  arl_timer u_arl_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(negedge clk) if (!rst && irq) irq_seen++;

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL R%0d: actual 0x%08h expected 0x%08h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] expv, input int req);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    check(req, bus_rdata, expv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(1, 32'(irq), 32'h0); // R1 interrupt low after reset
    for (int i = 0; i < NV; i++) begin
      case (int'(VEC[i].kind))
        K_WR:   wr(VEC[i].addr, VEC[i].data);
        K_RD:   rd(VEC[i].addr, VEC[i].expv, int'(VEC[i].req));
        K_IDLE: repeat (int'(VEC[i].data)) @(negedge clk);
        default: check(int'(VEC[i].req), 32'(irq_seen), VEC[i].expv);
      endcase
    end

    // R2 divide by 5 over 14 enabled cycles gives 2 ticks
    wr(8'h28, 32'd4);
    wr(8'h24, 32'd0);
    wr(8'h00, 32'h1);
    repeat (13) @(negedge clk);
    wr(8'h00, 32'h0);
    rd(8'h24, 32'd2, 2);

    // R1 reset mid-operation clears everything
    wr(8'h2C, 32'd5);
    wr(8'h38, 32'd9);
    wr(8'h00, 32'h1);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(8'h00, 32'h0, 1);
    rd(8'h2C, 32'h0, 1);
    rd(8'h38, 32'h0, 1);
    rd(8'h24, 32'h0, 1);
    rd(8'h28, 32'h0, 1);
    rd(8'h10, 32'h0, 1);
    check(1, 32'(irq), 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule